// File: doc/BRIEF.md
# Parallel Word Transfer Handshake Sequencer

This block sits between the message-handling core of a serial-bus remote terminal and the host subsystem. It paces each word of a message across a 16-bit parallel bus. A message-start pulse opens a message and raises the busy flag. The block then expects one command word followed by a number of data words. That number comes from a 5-bit word count field, where a field value of zero means thirty-two words. For each word it drives an active-low request and waits for an active-low grant from the host. It then runs a fixed transfer slot with a narrow active-low strobe placed in the middle of the slot, so that the host can latch on the strobe's rising edge.

The core signals each word with a single-cycle `word_rdy` pulse. The core side has no back-pressure. A pulse is taken only while the block is waiting for the next word, and a pulse at any other time is dropped. The host applies back-pressure only through the grant. If the grant is still absent when the timeout window closes, the block releases the request and abandons the rest of the message. It also drops a sticky failure flag that only the next message start clears. The word buffer is one register. For the command word and for words going to the host, it captures the core's word when the word is accepted. For words coming from the host, it captures the host's word at the strobe's rising edge.

Top module: `xfer_handshake`

## Requirements
- R1: After reset, `req_n`, `stb_n`, `cmd_n_data` and `hs_fail_n` are high, and `in_cmd` and `word_done` are low.
- R2: A `msg_start` pulse sampled high makes `in_cmd` high and `hs_fail_n` high in the next cycle. It also opens the command-word phase, in which `cmd_n_data` is low. The pulse restarts the sequencer from any state.
- R3: A `word_rdy` pulse taken while the sequencer waits for a word drives `req_n` low in the next cycle. A `word_rdy` pulse at any other time, including during a slot, raises no request.
- R4: A low `grant_n` sampled while `req_n` is low starts a transfer slot of `SLOT_CYC` (6) cycles. The host may release the grant after that without effect. `req_n` stays low through the slot and returns high in the cycle after it. A low `grant_n` while `req_n` is high starts nothing.
- R5: Within each slot, `stb_n` is low for exactly `STB_CYC` (2) cycles, in slot cycles 2 and 3, and it is high in every other cycle.
- R6: `cmd_n_data` is low throughout the command word's slot and high throughout every data word's slot.
- R7: A word count field of 1 to 31 gives that many data words after the command word, and a field of 0 gives 32. `in_cmd` falls in the cycle after the last data word's slot ends.
- R8: `word_done` pulses high for one cycle as each slot ends. At that point `xfer_word` holds the value of `core_word` taken with `word_rdy` for the command word, and for data words when `host_src` is 0. It holds the value of `host_word` sampled at the strobe's rising edge for data words when `host_src` is 1.
- R9: A grant that is first seen low on the `GNT_TMO`-th (24th) edge after `req_n` falls is still served. If the grant is still high on that edge, `req_n` returns high, `hs_fail_n` falls and `in_cmd` falls in the next cycle. The remaining words of the message are skipped.
- R10: Once low, `hs_fail_n` stays low whatever `word_rdy` and `grant_n` do. It returns high only with the next `msg_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_start | input | 1 | One-cycle pulse that opens a message |
| wc_field | input | 5 | Word count field, 0 means 32 data words |
| host_src | input | 1 | 1 when the host supplies the data words, 0 when it receives them |
| word_rdy | input | 1 | One-cycle pulse from the core that a word is ready to move |
| core_word | input | 16 | Word from the core |
| host_word | input | 16 | Word from the host |
| grant_n | input | 1 | Active-low grant from the host |
| req_n | output | 1 | Active-low transfer request to the host |
| in_cmd | output | 1 | High while a message is being serviced |
| cmd_n_data | output | 1 | Low during the command word, high for data words |
| stb_n | output | 1 | Active-low mid-slot strobe |
| hs_fail_n | output | 1 | Active-low sticky handshake failure |
| xfer_word | output | 16 | Word buffer contents |
| word_done | output | 1 | One-cycle pulse as each slot ends |

## Verification
Inputs change and outputs are read on the falling clock edge, so each result is read one rising edge after the event that causes it. `req_n` falls one cycle after `word_rdy` is taken. The slot's cycle 0 is the cycle after the edge that samples the grant low, and the strobe is low in slot cycles 2 and 3. `req_n` rises, `word_done` pulses and the buffer value is due one cycle after slot cycle 5. On a timeout, the bench reads `req_n` as still low after 23 grant-high edges, then reads the failure state after the 24th edge. Every check runs in the exact cycle given by counting those edges, never in a window.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2,
    ST_SLOT = 2'd3
  } hs_state_t;
endpackage

// File: rtl/hs_grant_timer.sv
module hs_grant_timer #(
  parameter int GNT_TMO = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = (GNT_TMO > 2) ? $clog2(GNT_TMO) : 1;

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(GNT_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (!run || expire)  cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  // R9
  tmr_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));
endmodule

// File: rtl/hs_slot_gen.sv
module hs_slot_gen #(
  parameter int SLOT_CYC = 6,
  parameter int STB_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic start,
  output logic active,
  output logic last,
  output logic latch_pt,
  output logic stb_n
);
  localparam int CW      = $clog2(SLOT_CYC);
  localparam int OFS     = (SLOT_CYC - STB_CYC) / 2;
  localparam int STB_END = OFS + STB_CYC - 1;

  logic [CW-1:0] cnt, cnt_nx;
  logic          act_nx, in_win;

  assign last     = active && (cnt == CW'(SLOT_CYC - 1));
  assign latch_pt = active && (cnt == CW'(STB_END));

  always_comb begin
    act_nx = active;
    cnt_nx = cnt;
    if (clear) begin
      act_nx = 1'b0;
      cnt_nx = '0;
    end else if (start) begin
      act_nx = 1'b1;
      cnt_nx = '0;
    end else if (active) begin
      if (last) begin
        act_nx = 1'b0;
        cnt_nx = '0;
      end else begin
        cnt_nx = cnt + 1'b1;
      end
    end
  end

  assign in_win = act_nx && (cnt_nx >= CW'(OFS)) && (cnt_nx <= CW'(STB_END));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      stb_n  <= 1'b1;
    end else begin
      active <= act_nx;
      cnt    <= cnt_nx;
      stb_n  <= ~in_win;
    end
  end

  // R5
  stb_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n |-> active);

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
endmodule

// File: rtl/hs_word_tracker.sv
module hs_word_tracker #(
  parameter int WCW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [WCW-1:0] wc_field,
  input  logic           dec,
  output logic           last_word
);
  localparam int RW = WCW + 1;

  logic [RW-1:0] rem;

  assign last_word = (rem == RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rem <= '0;
    else if (load)
      rem <= (wc_field == '0) ? RW'(1 << WCW) : {1'b0, wc_field};
    else if (dec)
      rem <= rem - 1'b1;
  end

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (rem != '0));
endmodule

// File: rtl/xfer_handshake.sv
module xfer_handshake
  import hs_pkg::*;
#(
  parameter int DW       = 16,
  parameter int WCW      = 5,
  parameter int GNT_TMO  = 24,
  parameter int SLOT_CYC = 6,
  parameter int STB_CYC  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           msg_start,
  input  logic [WCW-1:0] wc_field,
  input  logic           host_src,
  input  logic           word_rdy,
  input  logic [DW-1:0]  core_word,
  input  logic [DW-1:0]  host_word,
  input  logic           grant_n,
  output logic           req_n,
  output logic           in_cmd,
  output logic           cmd_n_data,
  output logic           stb_n,
  output logic           hs_fail_n,
  output logic [DW-1:0]  xfer_word,
  output logic           word_done
);
  hs_state_t state;
  logic      is_cmd, src_q;
  logic      expire, slot_act, slot_last, latch_pt, last_word;
  logic      slot_start, data_dec;

  assign slot_start = !msg_start && (state == ST_REQ) && !grant_n;
  assign data_dec   = !msg_start && (state == ST_SLOT) && slot_last && !is_cmd;
  assign cmd_n_data = ~is_cmd;

  hs_grant_timer #(.GNT_TMO(GNT_TMO)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == ST_REQ),
    .expire (expire)
  );

  hs_slot_gen #(.SLOT_CYC(SLOT_CYC), .STB_CYC(STB_CYC)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (msg_start),
    .start    (slot_start),
    .active   (slot_act),
    .last     (slot_last),
    .latch_pt (latch_pt),
    .stb_n    (stb_n)
  );

  hs_word_tracker #(.WCW(WCW)) u_wc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (msg_start),
    .wc_field  (wc_field),
    .dec       (data_dec),
    .last_word (last_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      is_cmd    <= 1'b0;
      src_q     <= 1'b0;
      in_cmd    <= 1'b0;
      req_n     <= 1'b1;
      hs_fail_n <= 1'b1;
      xfer_word <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (msg_start) begin
        state     <= ST_WAIT;
        is_cmd    <= 1'b1;
        src_q     <= host_src;
        in_cmd    <= 1'b1;
        req_n     <= 1'b1;
        hs_fail_n <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_WAIT: if (word_rdy) begin
            state <= ST_REQ;
            req_n <= 1'b0;
            if (is_cmd || !src_q) xfer_word <= core_word;
          end
          ST_REQ: begin
            if (!grant_n) begin
              state <= ST_SLOT;
            end else if (expire) begin
              state     <= ST_IDLE;
              req_n     <= 1'b1;
              hs_fail_n <= 1'b0;
              in_cmd    <= 1'b0;
              is_cmd    <= 1'b0;
            end
          end
          ST_SLOT: begin
            if (latch_pt && !is_cmd && src_q) xfer_word <= host_word;
            if (slot_last) begin
              req_n     <= 1'b1;
              word_done <= 1'b1;
              if (is_cmd) begin
                is_cmd <= 1'b0;
                state  <= ST_WAIT;
              end else if (last_word) begin
                state  <= ST_IDLE;
                in_cmd <= 1'b0;
              end else begin
                state  <= ST_WAIT;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLOT) |-> (!req_n && slot_act));

  // R10
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_fail_n && !msg_start) |=> !hs_fail_n);

  // R6
  cmd_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_n_data |-> in_cmd);

  // R9
  idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cmd |-> req_n);
endmodule

// File: tb/tb_xfer_handshake.sv
module tb_xfer_handshake;
  localparam int DW = 16, WCW = 5, TMO = 24, SLOT = 6, STB = 2;

  logic clk = 1'b0;
  logic rst_n, msg_start, host_src, word_rdy, grant_n;
  logic [WCW-1:0] wc_field;
  logic [DW-1:0]  core_word, host_word, xfer_word;
  logic req_n, in_cmd, cmd_n_data, stb_n, hs_fail_n, word_done;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  xfer_handshake #(.DW(DW), .WCW(WCW), .GNT_TMO(TMO), .SLOT_CYC(SLOT),
                   .STB_CYC(STB)) dut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .wc_field(wc_field),
    .host_src(host_src), .word_rdy(word_rdy), .core_word(core_word),
    .host_word(host_word), .grant_n(grant_n), .req_n(req_n), .in_cmd(in_cmd),
    .cmd_n_data(cmd_n_data), .stb_n(stb_n), .hs_fail_n(hs_fail_n),
    .xfer_word(xfer_word), .word_done(word_done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic start_msg(input logic [WCW-1:0] wc, input logic src);
    msg_start = 1'b1; wc_field = wc; host_src = src;
    step();
    msg_start = 1'b0;
    chk("R2", "in_cmd", in_cmd, 1);
    chk("R2", "cmd_n_data", cmd_n_data, 0);
    chk("R10", "hs_fail_n cleared", hs_fail_n, 1);
    chk("R2", "req_n", req_n, 1);
  endtask

  // One word: request, grant after gdly edges, full slot, end-of-slot results.
  task automatic do_word(input bit cmd, input int gdly, input logic [DW-1:0] cw,
                         input logic [DW-1:0] hw, input bit poke);
    core_word = cw; host_word = hw;
    word_rdy = 1'b1;
    step();
    word_rdy = 1'b0;
    core_word = ~cw;
    chk("R3", "req_n after word_rdy", req_n, 0);
    for (int d = 0; d < gdly; d++) begin
      step();
      chk("R4", "req_n while waiting grant", req_n, 0);
    end
    grant_n = 1'b0;
    step();
    grant_n = 1'b1;
    for (int i = 0; i < SLOT; i++) begin
      if (i > 0) step();
      chk("R5", $sformatf("stb_n slot cycle %0d", i), stb_n, (i == 2 || i == 3) ? 0 : 1);
      chk("R6", "cmd_n_data in slot", cmd_n_data, cmd ? 0 : 1);
      chk("R4", "req_n in slot", req_n, 0);
      if (poke && i == 1) word_rdy = 1'b1;
      if (poke && i == 2) word_rdy = 1'b0;
    end
    step();
    host_word = ~hw;
    chk("R4", "req_n after slot", req_n, 1);
    chk("R8", "word_done", word_done, 1);
    chk("R8", "xfer_word", xfer_word, (cmd || !host_src) ? cw : hw);
    if (poke) begin
      repeat (3) step();
      chk("R3", "word_rdy in slot ignored", req_n, 1);
    end
  endtask

  task automatic t_reset();
    chk("R1", "req_n", req_n, 1);
    chk("R1", "stb_n", stb_n, 1);
    chk("R1", "cmd_n_data", cmd_n_data, 1);
    chk("R1", "hs_fail_n", hs_fail_n, 1);
    chk("R1", "in_cmd", in_cmd, 0);
    chk("R1", "word_done", word_done, 0);
  endtask

  task automatic t_receive();
    start_msg(5'd3, 1'b0);
    grant_n = 1'b0;
    repeat (3) begin
      step();
      chk("R4", "grant without request", req_n, 1);
      chk("R4", "no strobe without request", stb_n, 1);
    end
    grant_n = 1'b1;
    do_word(1'b1, 0, 16'h8421, 16'h0000, 1'b1);
    do_word(1'b0, 2, 16'h1234, 16'hFFFF, 1'b0);
    chk("R7", "in_cmd mid message", in_cmd, 1);
    do_word(1'b0, 5, 16'hA5A5, 16'h0F0F, 1'b0);
    do_word(1'b0, TMO - 1, 16'h5A5A, 16'h0000, 1'b0);
    chk("R7", "in_cmd after last of 3", in_cmd, 0);
    chk("R9", "late grant served", hs_fail_n, 1);
  endtask

  task automatic t_transmit();
    start_msg(5'd1, 1'b1);
    do_word(1'b1, 1, 16'hC0DE, 16'h1111, 1'b0);
    do_word(1'b0, 3, 16'h2222, 16'hBEEF, 1'b0);
    chk("R7", "in_cmd after single word", in_cmd, 0);
  endtask

  task automatic t_full_count();
    start_msg(5'd0, 1'b0);
    do_word(1'b1, 0, 16'h0001, 16'h0, 1'b0);
    for (int k = 0; k < 32; k++) begin
      do_word(1'b0, 0, DW'(k + 16'h100), 16'h0, 1'b0);
      chk("R7", $sformatf("in_cmd after word %0d of 32", k + 1), in_cmd, (k < 31) ? 1 : 0);
    end
  endtask

  task automatic t_timeout();
    start_msg(5'd2, 1'b0);
    do_word(1'b1, 0, 16'h7777, 16'h0, 1'b0);
    word_rdy = 1'b1;
    step();
    word_rdy = 1'b0;
    chk("R3", "req_n data word", req_n, 0);
    repeat (TMO - 1) step();
    chk("R9", "req_n before expiry", req_n, 0);
    step();
    chk("R9", "req_n after expiry", req_n, 1);
    chk("R9", "hs_fail_n after expiry", hs_fail_n, 0);
    chk("R9", "in_cmd after expiry", in_cmd, 0);
    word_rdy = 1'b1; grant_n = 1'b0;
    step();
    word_rdy = 1'b0;
    repeat (3) step();
    grant_n = 1'b1;
    chk("R9", "remaining words skipped", req_n, 1);
    chk("R9", "no strobe after expiry", stb_n, 1);
    chk("R10", "hs_fail_n sticky", hs_fail_n, 0);
    start_msg(5'd1, 1'b0);
    do_word(1'b1, 0, 16'h3C3C, 16'h0, 1'b0);
    do_word(1'b0, 0, 16'h4B4B, 16'h0, 1'b0);
    chk("R10", "hs_fail_n after clean message", hs_fail_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_start = 1'b0; word_rdy = 1'b0; grant_n = 1'b1;
    host_src = 1'b0; wc_field = '0; core_word = '0; host_word = '0;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_receive();
    t_transmit();
    t_full_count();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule